// File: doc/BRIEF.md
# Packed Lane Shifter

This block shifts every lane of a packed data word by one common amount, in a single registered stage. The word holds either two 16-bit lanes or four 8-bit lanes. The register indices that travel with the operation select the lane width; no separate width field is used. Three shift kinds are provided: arithmetic right, logical right and logical left. The amount comes either from a second data word or from a 4-bit immediate.

A 2-bit mode field picks the plain shift or a modified one. On right shifts the modified form rounds the result. On left shifts it saturates the result to the signed range of the lane. Encodings that cannot be honoured raise an illegal flag and force the result to zero. Such encodings are indices outside both ranges, indices from different ranges, reserved modes and the reserved kind. The surrounding datapath supplies operands that have already been read from the register file, and it consumes the registered result.

Top module: `pshift_unit`

## Requirements
- R1: When every checked index lies in 16..29, the word is treated as two 16-bit lanes (bits 15:0 and 31:16). When every checked index lies in 2..15, it is treated as four 8-bit lanes (bits 8i+7:8i). All lanes use the same amount.
- R2: The amount is the low 4 bits (16-bit lanes) or the low 3 bits (8-bit lanes) of `amt_word` when `use_imm`=0, or of `imm` when `use_imm`=1. All higher bits are ignored.
- R3: `kind` 00 is an arithmetic right shift, 01 a logical right shift and 10 a logical left shift. `kind` 11 is reserved and illegal.
- R4: `mode` 00 gives the plain shift of each kind, with the left shift truncated to the lane width.
- R5: `mode` 01 on either right shift adds the last bit shifted out to the shifted lane. An amount of zero returns the lane unchanged.
- R6: `mode` 01 on the left shift treats lanes as signed. If the shifted value does not fit the signed lane range, the lane is clamped to the signed maximum (positive input) or the signed minimum (negative input).
- R7: An index outside both ranges, indices from different ranges, or `mode` 10/11 sets `illegal`=1 with `result`=0.
- R8: With `use_imm`=1, only `rd_idx` and `rs1_idx` are range-checked, and `rs2_idx` has no effect. With `use_imm`=0, all three are checked.
- R9: `out_valid` follows `in_valid` one clock later, and `result`/`illegal` take the new values in that same cycle. When `in_valid`=0, `result` and `illegal` hold their values.
- R10: While `rst_n`=0, `out_valid`, `illegal` and `result` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| kind | input | 2 | Shift kind (00 arith right, 01 logical right, 10 left) |
| mode | input | 2 | 00 plain, 01 round (right) / saturate (left) |
| use_imm | input | 1 | Amount taken from `imm` instead of `amt_word` |
| rd_idx | input | 5 | Destination index |
| rs1_idx | input | 5 | Operand source index |
| rs2_idx | input | 5 | Amount source index |
| operand | input | 32 | Packed data to shift |
| amt_word | input | 32 | Packed word whose lowest lane gives the amount |
| imm | input | 4 | Immediate amount |
| out_valid | output | 1 | Result valid |
| result | output | 32 | Shifted packed word |
| illegal | output | 1 | Encoding rejected |

## Verification
Two functions can act on one operation in the same cycle: the per-lane modifier (rounding carry or saturation clamp) and the illegal-encoding override. The bench provokes the overlap with operands that would clamp or round in some lanes, paired with a mixed index set or a reserved mode. It judges the result as all zeros with the flag set. It also mixes clamped and unclamped lanes within one legal word and checks each lane against a behavioural reference model that is evaluated on every clock.

// File: rtl/simd_shift_pkg.sv
package simd_shift_pkg;

    localparam int PS_WORD_W = 32;
    localparam int PS_IDX_W  = 5;

    typedef enum logic [1:0] {
        SK_SRA  = 2'b00,
        SK_SRL  = 2'b01,
        SK_SLL  = 2'b10,
        SK_RSVD = 2'b11
    } shift_kind_e;

    typedef enum logic [1:0] {
        SM_PLAIN = 2'b00,
        SM_ALT   = 2'b01,
        SM_RSV2  = 2'b10,
        SM_RSV3  = 2'b11
    } shift_mode_e;

endpackage

// File: rtl/pshift_decode.sv
module pshift_decode
    import simd_shift_pkg::*;
#(
    parameter int IDX_W  = PS_IDX_W,
    parameter int WIDE_LO = 16,
    parameter int WIDE_HI = 29,
    parameter int NARR_LO = 2,
    parameter int NARR_HI = 15
) (
    input  shift_kind_e      kind,
    input  shift_mode_e      mode,
    input  logic             use_imm,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [IDX_W-1:0] rs1_idx,
    input  logic [IDX_W-1:0] rs2_idx,
    output logic             wide,
    output logic             bad
);
    function automatic logic in_span(input logic [IDX_W-1:0] v, input int lo, input int hi);
        return (int'(v) >= lo) && (int'(v) <= hi);
    endfunction

    logic all_wide, all_narr, enc_bad;

    always_comb begin
        all_wide = in_span(rd_idx, WIDE_LO, WIDE_HI) && in_span(rs1_idx, WIDE_LO, WIDE_HI)
                 && (use_imm || in_span(rs2_idx, WIDE_LO, WIDE_HI));
        all_narr = in_span(rd_idx, NARR_LO, NARR_HI) && in_span(rs1_idx, NARR_LO, NARR_HI)
                 && (use_imm || in_span(rs2_idx, NARR_LO, NARR_HI));
        enc_bad  = (kind == SK_RSVD) || (mode == SM_RSV2) || (mode == SM_RSV3);
        wide     = all_wide;
        bad      = enc_bad || !(all_wide || all_narr);
    end
endmodule

// File: rtl/pshift_lane.sv
module pshift_lane
    import simd_shift_pkg::*;
#(
    parameter int W  = 16,
    parameter int SW = 4
) (
    input  logic [W-1:0]  x,
    input  logic [SW-1:0] s,
    input  shift_kind_e   kind,
    input  logic          alt,
    output logic [W-1:0]  y
);
    localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] sra_v, srl_v, sll_v, back_v, tail_v;
    logic         rbit, ovf;

    always_comb begin
        sra_v  = W'($signed(x) >>> s);
        srl_v  = x >> s;
        sll_v  = x << s;
        back_v = W'($signed(sll_v) >>> s);
        ovf    = (back_v != x);
        tail_v = (s == '0) ? '0 : (x >> (s - SW'(1)));
        rbit   = (s != '0) && tail_v[0];
        case (kind)
            SK_SRA:  y = sra_v + ((alt && rbit) ? W'(1) : '0);
            SK_SRL:  y = srl_v + ((alt && rbit) ? W'(1) : '0);
            SK_SLL:  y = (alt && ovf) ? (x[W-1] ? SMIN : SMAX) : sll_v;
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/pshift_unit.sv
module pshift_unit
    import simd_shift_pkg::*;
#(
    parameter int WORD_W = PS_WORD_W,
    parameter int IDX_W  = PS_IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        kind,
    input  logic [1:0]        mode,
    input  logic              use_imm,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [IDX_W-1:0]  rs1_idx,
    input  logic [IDX_W-1:0]  rs2_idx,
    input  logic [WORD_W-1:0] operand,
    input  logic [WORD_W-1:0] amt_word,
    input  logic [3:0]        imm,
    output logic              out_valid,
    output logic [WORD_W-1:0] result,
    output logic              illegal
);
    localparam int N16 = WORD_W / 16;
    localparam int N8  = WORD_W / 8;

    typedef struct packed {
        logic              vld;
        logic              ill;
        logic [WORD_W-1:0] res;
    } unit_state_t;

    unit_state_t st_d, st_q;

    shift_kind_e       kind_e;
    shift_mode_e       mode_e;
    logic              is_wide, is_bad, alt;
    logic [3:0]        amt_src;
    logic [WORD_W-1:0] y16, y8;

    assign kind_e  = shift_kind_e'(kind);
    assign mode_e  = shift_mode_e'(mode);
    assign alt     = (mode_e == SM_ALT);
    assign amt_src = use_imm ? imm : amt_word[3:0];

    pshift_decode #(.IDX_W(IDX_W)) u_dec (
        .kind    (kind_e),
        .mode    (mode_e),
        .use_imm (use_imm),
        .rd_idx  (rd_idx),
        .rs1_idx (rs1_idx),
        .rs2_idx (rs2_idx),
        .wide    (is_wide),
        .bad     (is_bad)
    );

    for (genvar g = 0; g < N16; g++) begin : g_l16
        pshift_lane #(.W(16), .SW(4)) u_lane (
            .x    (operand[g*16 +: 16]),
            .s    (amt_src[3:0]),
            .kind (kind_e),
            .alt  (alt),
            .y    (y16[g*16 +: 16])
        );
    end

    for (genvar g = 0; g < N8; g++) begin : g_l8
        pshift_lane #(.W(8), .SW(3)) u_lane (
            .x    (operand[g*8 +: 8]),
            .s    (amt_src[2:0]),
            .kind (kind_e),
            .alt  (alt),
            .y    (y8[g*8 +: 8])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.ill = is_bad;
            st_d.res = is_bad ? '0 : (is_wide ? y16 : y8);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign result    = st_q.res;
    assign illegal   = st_q.ill;
endmodule

// File: rtl/pshift_unit_checks.sv
module pshift_unit_checks #(
    parameter int WORD_W = 32,
    parameter int IDX_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [1:0]        kind,
    input logic [1:0]        mode,
    input logic              use_imm,
    input logic [IDX_W-1:0]  rd_idx,
    input logic [IDX_W-1:0]  rs1_idx,
    input logic [IDX_W-1:0]  rs2_idx,
    input logic [WORD_W-1:0] operand,
    input logic [WORD_W-1:0] amt_word,
    input logic              out_valid,
    input logic [WORD_W-1:0] result,
    input logic              illegal
);
    logic all16;
    assign all16 = (rd_idx >= 16) && (rd_idx <= 29) && (rs1_idx >= 16) && (rs1_idx <= 29)
                && (rs2_idx >= 16) && (rs2_idx <= 29);

    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R9
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(result) && $stable(illegal))); // R9
    AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (result == '0)); // R7
    AST_BAD_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode[1]) |=> illegal); // R7
    AST_BAD_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && kind == 2'b11) |=> illegal); // R3
    AST_ZERO_AMOUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && all16 && !use_imm && !mode[1] && kind != 2'b11 && amt_word[3:0] == 4'd0)
        |=> (result == $past(operand))); // R5
endmodule

bind pshift_unit pshift_unit_checks #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .kind      (kind),
    .mode      (mode),
    .use_imm   (use_imm),
    .rd_idx    (rd_idx),
    .rs1_idx   (rs1_idx),
    .rs2_idx   (rs2_idx),
    .operand   (operand),
    .amt_word  (amt_word),
    .out_valid (out_valid),
    .result    (result),
    .illegal   (illegal)
);

// File: tb/pshift_unit_tb.sv
`timescale 1ns/1ps
module pshift_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  kind = 2'b00;
    logic [1:0]  mode = 2'b00;
    logic        use_imm = 1'b0;
    logic [4:0]  rd_idx = 5'd0, rs1_idx = 5'd0, rs2_idx = 5'd0;
    logic [31:0] operand = '0, amt_word = '0;
    logic [3:0]  imm = '0;
    logic        out_valid, illegal;
    logic [31:0] result;

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    running  = 1'b0;
    string cur_tag  = "R10";

    logic        exp_vld = 1'b0, exp_ill = 1'b0;
    logic [31:0] exp_res = '0;
    string       exp_tag = "R10";
    logic        m_ill;
    logic [31:0] m_res;

    always #5 clk = ~clk;

    pshift_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .kind(kind), .mode(mode),
        .use_imm(use_imm), .rd_idx(rd_idx), .rs1_idx(rs1_idx), .rs2_idx(rs2_idx),
        .operand(operand), .amt_word(amt_word), .imm(imm),
        .out_valid(out_valid), .result(result), .illegal(illegal)
    );

    function automatic bit span(input logic [4:0] v, input int lo, input int hi);
        return (int'(v) >= lo) && (int'(v) <= hi);
    endfunction

    function automatic void ref_model(input logic [1:0] k, input logic [1:0] m,
            input logic [4:0] d, input logic [4:0] a, input logic [4:0] b, input logic ui,
            input logic [31:0] op, input logic [31:0] am, input logic [3:0] im,
            output logic ill, output logic [31:0] res);
        bit ok16, ok8;
        int w, s;
        longint mask, smax, smin;
        ok16 = span(d,16,29) && span(a,16,29) && (ui || span(b,16,29));
        ok8  = span(d,2,15)  && span(a,2,15)  && (ui || span(b,2,15));
        ill  = !(ok16 || ok8) || m[1] || (k == 2'b11);
        res  = '0;
        if (ill) return;
        w    = ok16 ? 16 : 8;
        s    = int'(ui ? im : am[3:0]) % w;
        mask = (longint'(1) << w) - 1;
        smax = (longint'(1) << (w-1)) - 1;
        smin = -(longint'(1) << (w-1));
        for (int i = 0; i < 32 / w; i++) begin
            longint v, sv, r;
            v  = (longint'(op) >> (i*w)) & mask;
            sv = (v > smax) ? v - (mask + 1) : v;
            if (k == 2'b00) begin
                r = sv >>> s;
                if (m[0] && s > 0) r = r + ((v >> (s-1)) & 1);
            end else if (k == 2'b01) begin
                r = v >> s;
                if (m[0] && s > 0) r = r + ((v >> (s-1)) & 1);
            end else begin
                r = sv * (longint'(1) << s);
                if (m[0]) begin
                    if (r > smax) r = smax;
                    if (r < smin) r = smin;
                end
            end
            res = res | 32'((r & mask) << (i*w));
        end
    endfunction

    // behavioural reference, advanced every clock
    always @(posedge clk) begin
        if (!rst_n) begin
            exp_vld <= 1'b0; exp_ill <= 1'b0; exp_res <= '0;
        end else begin
            exp_vld <= in_valid;
            if (in_valid) begin
                ref_model(kind, mode, rd_idx, rs1_idx, rs2_idx, use_imm, operand, amt_word, imm, m_ill, m_res);
                exp_ill <= m_ill;
                exp_res <= m_res;
                exp_tag <= cur_tag;
            end
        end
    end

    always @(negedge clk) begin
        if (running) begin
            n_checks++;
            if (out_valid !== exp_vld || illegal !== exp_ill || result !== exp_res) begin
                n_fail++;
                $display("FAIL %s: got vld=%0b ill=%0b res=%h, expected vld=%0b ill=%0b res=%h",
                         exp_tag, out_valid, illegal, result, exp_vld, exp_ill, exp_res);
            end
        end
    end

    task automatic apply(input logic [1:0] k, input logic [1:0] m, input logic [4:0] d,
            input logic [4:0] a, input logic [4:0] b, input logic ui, input logic [31:0] op,
            input logic [31:0] am, input logic [3:0] im, input string tag);
        @(negedge clk);
        in_valid = 1'b1; kind = k; mode = m; rd_idx = d; rs1_idx = a; rs2_idx = b;
        use_imm = ui; operand = op; amt_word = am; imm = im; cur_tag = tag;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            operand  = 32'hDEAD_BEEF;   // R9: must not disturb held output
            cur_tag  = "R9";
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got no completion, expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: reset state
        n_checks++;
        if (out_valid !== 1'b0 || illegal !== 1'b0 || result !== '0) begin
            n_fail++;
            $display("FAIL R10: got vld=%0b ill=%0b res=%h, expected 0 0 00000000", out_valid, illegal, result);
        end
        rst_n = 1'b1;
        running = 1'b1;
        // R1 / R4: both widths, plain shifts
        apply(2'b01, 2'b00, 5'd16, 5'd20, 5'd29, 1'b0, 32'h8000_0100, 32'h0000_0004, 4'd0, "R1");
        apply(2'b01, 2'b00, 5'd2,  5'd7,  5'd15, 1'b0, 32'h80F0_0F01, 32'h0000_0003, 4'd0, "R1");
        apply(2'b00, 2'b00, 5'd17, 5'd18, 5'd19, 1'b0, 32'h8000_7FF0, 32'h0000_0005, 4'd0, "R4");
        apply(2'b10, 2'b00, 5'd3,  5'd4,  5'd5,  1'b0, 32'h81C3_7F01, 32'h0000_0002, 4'd0, "R4");
        // R2: junk above amount field, immediate source
        apply(2'b01, 2'b00, 5'd16, 5'd16, 5'd16, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFF2, 4'd0, "R2");
        apply(2'b01, 2'b00, 5'd2,  5'd2,  5'd2,  1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFE, 4'd0, "R2");
        apply(2'b00, 2'b00, 5'd21, 5'd22, 5'd0,  1'b1, 32'hF000_1234, 32'h0000_0007, 4'd8, "R2");
        // R3: each kind, reserved kind
        apply(2'b00, 2'b00, 5'd16, 5'd16, 5'd16, 1'b0, 32'hC000_C000, 32'd3, 4'd0, "R3");
        apply(2'b01, 2'b00, 5'd16, 5'd16, 5'd16, 1'b0, 32'hC000_C000, 32'd3, 4'd0, "R3");
        apply(2'b10, 2'b00, 5'd16, 5'd16, 5'd16, 1'b0, 32'hC000_C000, 32'd3, 4'd0, "R3");
        apply(2'b11, 2'b00, 5'd16, 5'd16, 5'd16, 1'b0, 32'hC000_C000, 32'd3, 4'd0, "R3");
        // R5: rounding, zero amount
        apply(2'b00, 2'b01, 5'd16, 5'd16, 5'd16, 1'b0, 32'hFFFF_0003, 32'd1, 4'd0, "R5");
        apply(2'b01, 2'b01, 5'd2,  5'd2,  5'd2,  1'b0, 32'hFF07_0580, 32'd2, 4'd0, "R5");
        apply(2'b00, 2'b01, 5'd16, 5'd16, 5'd16, 1'b0, 32'h8001_7FFF, 32'd0, 4'd0, "R5");
        apply(2'b01, 2'b01, 5'd9,  5'd9,  5'd9,  1'b1, 32'h7F80_FF01, 32'd0, 4'd7, "R5");
        // R6: saturation mixed with unclamped lanes in one word
        apply(2'b10, 2'b01, 5'd16, 5'd16, 5'd16, 1'b0, 32'h4000_0123, 32'd1, 4'd0, "R6");
        apply(2'b10, 2'b01, 5'd16, 5'd16, 5'd16, 1'b0, 32'h8001_FFC0, 32'd1, 4'd0, "R6");
        apply(2'b10, 2'b01, 5'd2,  5'd2,  5'd2,  1'b0, 32'h40C0_F01F, 32'd2, 4'd0, "R6");
        // R7: illegal overrides a clamping operand
        apply(2'b10, 2'b01, 5'd16, 5'd2,  5'd16, 1'b0, 32'h4000_4000, 32'd1, 4'd0, "R7");
        apply(2'b00, 2'b00, 5'd30, 5'd30, 5'd30, 1'b0, 32'h1234_5678, 32'd1, 4'd0, "R7");
        apply(2'b00, 2'b00, 5'd1,  5'd2,  5'd2,  1'b0, 32'h1234_5678, 32'd1, 4'd0, "R7");
        apply(2'b01, 2'b10, 5'd16, 5'd16, 5'd16, 1'b0, 32'hFFFF_FFFF, 32'd1, 4'd0, "R7");
        apply(2'b01, 2'b11, 5'd2,  5'd2,  5'd2,  1'b0, 32'hFFFF_FFFF, 32'd1, 4'd0, "R7");
        // R8: rs2 ignored with immediate, checked without
        apply(2'b01, 2'b00, 5'd16, 5'd17, 5'd31, 1'b1, 32'hF0F0_F0F0, 32'd0, 4'd4, "R8");
        apply(2'b01, 2'b00, 5'd16, 5'd17, 5'd31, 1'b0, 32'hF0F0_F0F0, 32'd4, 4'd0, "R8");
        apply(2'b10, 2'b00, 5'd2,  5'd3,  5'd20, 1'b1, 32'h0102_0304, 32'd0, 4'd1, "R8");
        // R9: hold across idle cycles
        idle(4);
        apply(2'b10, 2'b00, 5'd2,  5'd2,  5'd2,  1'b0, 32'h0101_0101, 32'd1, 4'd0, "R9");
        idle(3);
        // R1: mixed random traffic in both widths
        for (int i = 0; i < 400; i++) begin
            logic [4:0] base;
            base = ($urandom_range(0, 1) == 1) ? 5'd16 : 5'd2;
            apply(2'($urandom_range(0, 3)), 2'($urandom_range(0, 4) == 0 ? 2 : $urandom_range(0, 1)),
                  base + 5'($urandom_range(0, 13)), base + 5'($urandom_range(0, 13)),
                  ($urandom_range(0, 9) == 0) ? 5'd31 : base + 5'($urandom_range(0, 13)),
                  1'($urandom_range(0, 1)), $urandom, $urandom, 4'($urandom_range(0, 15)), "R1");
            if ($urandom_range(0, 5) == 0) idle(1);
        end
        idle(2);
        running = 1'b0;
        finish_run();
    end
endmodule